// File: doc/BRIEF.md
# Reloadable Up-Counter PWM Generator

This block generates a single pulse-width-modulated signal from a 12-bit up-counter. The counter runs from its current value to the top of its range (4095). It then wraps, and instead of restarting from zero it restarts from a programmable base value. This shortens the period to `4096 - base` clock cycles. At every wrap a staged duty threshold becomes the active threshold and the waveform starts a new high phase. The waveform falls when the counter reaches the active threshold.

Software programs the block through a byte-wide write port. The base value and the duty threshold are each written as a low byte plus a high byte that carries the top four bits. The duty threshold is double-buffered. Writing its high byte suspends the falling-edge compare, and writing its low byte re-arms it, so that a half-written threshold never ends a pulse early. A control byte selects output enable and polarity. A one-cycle overflow pulse marks each wrap.

Top module: `arpwm_timer`

## Requirements
- R1: After reset the counter is 0, `pwm_out` and `ovf_pulse` are low, and all stored values (base, staged and active threshold, control) are zero. The first `ovf_pulse` is seen 4096 cycles after reset is released.
- R2: The counter increments by one each cycle until it reaches 4095. At the next edge it loads the base value, so consecutive overflow pulses are exactly `4096 - base` cycles apart.
- R3: `ovf_pulse` is high for exactly one cycle per period: the cycle in which the counter holds the freshly loaded base value.
- R4: Writes to address 0 (base bits 7:0) or address 1 (base bits 11:8 from data bits 3:0) leave the period in progress unchanged and apply from the next wrap. A stored base of 4095 is used as 4094.
- R5: Writes to address 3 (threshold bits 7:0) and address 2 (threshold bits 11:8 from data bits 3:0) only stage the threshold. The staged value becomes active at the next wrap, so the current period's waveform is unchanged.
- R6: With polarity 0 and enable set, `pwm_out` is high for `threshold - base` cycles from the start of each period when threshold > base. It is high for 0 cycles when threshold <= base.
- R7: A write to address 2 disables the falling-edge compare, so a period that starts high stays high until the next wrap. A write to address 3 re-enables the compare.
- R8: Control bit 1 (address 4) inverts the waveform, so high time becomes `period - (threshold - base)`. Threshold equal to base then gives 100% duty.
- R9: With control bit 0 (address 4) clear, `pwm_out` is held at 0 while the counter and `ovf_pulse` keep running at the same period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0/1 base lo/hi, 2/3 threshold hi/lo, 4 control) |
| wr_data | input | 8 | Write data byte |
| pwm_out | output | 1 | Registered PWM output |
| ovf_pulse | output | 1 | One-cycle overflow pulse |

## Verification
The situation hardest to reach is a period that starts while the compare is locked after a lone high-byte write. It shows only as a waveform that fails to fall at its threshold. The bench writes the high byte alone, then measures a full period between overflow pulses and expects the output high throughout. It then completes the low byte and checks that the new threshold governs the following period. Mid-period writes to the base and threshold are issued on the cycle right after an overflow pulse. This proves they leave the running period untouched and land at the next wrap.

// File: rtl/arpwm_pkg.sv
package arpwm_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    SEL_BASE_LO = 3'd0,
    SEL_BASE_HI = 3'd1,
    SEL_THR_HI  = 3'd2,
    SEL_THR_LO  = 3'd3,
    SEL_CTRL    = 3'd4
  } reg_sel_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_POL_BIT = 1;
endpackage

// File: rtl/arpwm_regs.sv
module arpwm_regs
  import arpwm_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wrap,
  output logic [CNT_W-1:0]  base_eff,
  output logic [CNT_W-1:0]  thr_stage,
  output logic [CNT_W-1:0]  thr_act,
  output logic              cmp_lock,
  output logic              ctl_en,
  output logic              ctl_pol
);
  // CNT_W must lie between DATA_W+1 and 2*DATA_W-1
  localparam int HI_W = CNT_W - DATA_W;
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] base_q;
  logic             unused_bits;

  assign unused_bits = ^wr_data[DATA_W-1:HI_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      thr_stage <= '0;
      cmp_lock  <= 1'b0;
      ctl_en    <= 1'b0;
      ctl_pol   <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        SEL_BASE_LO: base_q[DATA_W-1:0]     <= wr_data;
        SEL_BASE_HI: base_q[CNT_W-1:DATA_W] <= wr_data[HI_W-1:0];
        SEL_THR_HI: begin
          thr_stage[CNT_W-1:DATA_W] <= wr_data[HI_W-1:0];
          cmp_lock                  <= 1'b1;
        end
        SEL_THR_LO: begin
          thr_stage[DATA_W-1:0] <= wr_data;
          cmp_lock              <= 1'b0;
        end
        SEL_CTRL: begin
          ctl_en  <= wr_data[CTRL_EN_BIT];
          ctl_pol <= wr_data[CTRL_POL_BIT];
        end
        default: ;
      endcase
    end
  end

  // active threshold follows the staged one only at a wrap
  always_ff @(posedge clk) begin
    if (rst)       thr_act <= '0;
    else if (wrap) thr_act <= thr_stage;
  end

  // the top count can never be a base: the period must be at least two cycles
  assign base_eff = (base_q == TOP) ? TOP - 1'b1 : base_q;
endmodule

// File: rtl/arpwm_counter.sv
module arpwm_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] base_eff,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap,
  output logic             ovf_q
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assign wrap = (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= wrap ? base_eff : CNT_W'(cnt_q + 1'b1);
      ovf_q <= wrap;
    end
  end
endmodule

// File: rtl/arpwm_wave.sv
module arpwm_wave #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             wrap,
  input  logic [CNT_W-1:0] base_eff,
  input  logic [CNT_W-1:0] thr_stage,
  input  logic [CNT_W-1:0] thr_act,
  input  logic             cmp_lock,
  input  logic             ctl_en,
  input  logic             ctl_pol,
  output logic             pwm_q
);
  logic             raw_q, raw_nxt;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = CNT_W'(cnt_q + 1'b1);

  // raw level is computed for the counter value of the next cycle,
  // so the registered output lines up with the counter
  always_comb begin
    raw_nxt = raw_q;
    if (wrap)
      raw_nxt = (thr_stage > base_eff);
    else if (!cmp_lock && cnt_inc == thr_act)
      raw_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= 1'b0;
      pwm_q <= 1'b0;
    end else begin
      raw_q <= raw_nxt;
      pwm_q <= ctl_en & (raw_nxt ^ ctl_pol);
    end
  end
endmodule

// File: rtl/arpwm_timer.sv
module arpwm_timer
  import arpwm_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_out,
  output logic              ovf_pulse
);
  logic [CNT_W-1:0] cnt_q, base_eff, thr_stage, thr_act;
  logic             wrap, cmp_lock, ctl_en, ctl_pol;

  arpwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wrap(wrap), .base_eff(base_eff), .thr_stage(thr_stage), .thr_act(thr_act),
    .cmp_lock(cmp_lock), .ctl_en(ctl_en), .ctl_pol(ctl_pol)
  );

  arpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .base_eff(base_eff),
    .cnt_q(cnt_q), .wrap(wrap), .ovf_q(ovf_pulse)
  );

  arpwm_wave #(.CNT_W(CNT_W)) u_wave (
    .clk(clk), .rst(rst), .cnt_q(cnt_q), .wrap(wrap), .base_eff(base_eff),
    .thr_stage(thr_stage), .thr_act(thr_act), .cmp_lock(cmp_lock),
    .ctl_en(ctl_en), .ctl_pol(ctl_pol), .pwm_q(pwm_out)
  );
endmodule

// File: rtl/arpwm_checker.sv
module arpwm_checker #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] base_eff,
  input logic [CNT_W-1:0] thr_stage,
  input logic [CNT_W-1:0] thr_act,
  input logic             en,
  input logic             pwm_out,
  input logic             ovf_pulse
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt != TOP) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));              // R2
  AST_WRAP_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP) |=> (cnt == $past(base_eff)));                          // R4
  AST_OVF_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP) |=> ovf_pulse);                                         // R3
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |=> !ovf_pulse);                                           // R3
  AST_THR_XFER: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP) |=> (thr_act == $past(thr_stage)));                     // R5
  AST_THR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cnt != TOP) |=> $stable(thr_act));                                  // R5
  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_out);                                                   // R9
endmodule

bind arpwm_timer arpwm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt_q), .base_eff(base_eff),
  .thr_stage(thr_stage), .thr_act(thr_act), .en(ctl_en),
  .pwm_out(pwm_out), .ovf_pulse(ovf_pulse)
);

// File: tb/sim_arpwm_timer.sv
`timescale 1ns/1ps
module sim_arpwm_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out, ovf_pulse;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  arpwm_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .ovf_pulse(ovf_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_base(input int v);
    wr(3'd0, v[7:0]);
    wr(3'd1, {4'h0, v[11:8]});
  endtask

  task automatic set_thr(input int v);
    wr(3'd2, {4'h0, v[11:8]});
    wr(3'd3, v[7:0]);
  endtask

  // Align to an overflow sample, optionally issue one write in the first
  // cycle of the period, and measure period length and high cycles.
  task automatic measure(input bit do_wr, input logic [2:0] a, input logic [7:0] d,
                         output int per, output int hi);
    do @(negedge clk); while (!ovf_pulse);
    per = 0; hi = 0;
    if (do_wr) begin
      wr_en = 1'b1; wr_addr = a; wr_data = d;
    end
    do begin
      hi += int'(pwm_out);
      per++;
      @(negedge clk);
      wr_en = 1'b0;
      if (per == 1) check(!ovf_pulse, "R3 ovf single cycle", int'(ovf_pulse), 0);
    end while (!ovf_pulse);
  endtask

  function automatic int exp_high(input int base, input int thr, input bit pol, input bit en);
    int b, p, h;
    b = (base > 4094) ? 4094 : base;
    p = 4096 - b;
    h = (thr > b) ? thr - b : 0;
    if (!en) return 0;
    return pol ? p - h : h;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int per, hi, n;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pwm_out == 1'b0, "R1 pwm low in reset", int'(pwm_out), 0);
    check(ovf_pulse == 1'b0, "R1 ovf low in reset", int'(ovf_pulse), 0);
    rst = 1'b0;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (pwm_out) check(0, "R1 pwm low before first wrap", 1, 0);
    end while (!ovf_pulse && n < 5000);
    check(n == 4096, "R1 first overflow from zero", n, 4096);

    // R2 R6 R8: sweep threshold around base 4088 for both polarities
    set_base(4088);
    for (int pol = 0; pol < 2; pol++) begin
      wr(3'd4, {6'd0, pol[0], 1'b1});
      for (int t = 4086; t <= 4095; t++) begin
        set_thr(t);
        measure(1'b0, 3'd0, 8'd0, per, hi);
        check(per == 8, "R2 period 4096-base", per, 8);
        check(hi == exp_high(4088, t, pol[0], 1'b1),
              pol ? "R8 inverted high time" : "R6 high time", hi,
              exp_high(4088, t, pol[0], 1'b1));
      end
    end
    wr(3'd4, 8'h01);

    // R2 R4: several bases, including the clamped top value
    foreach (n_list[i]) begin
      set_base(n_list[i]);
      set_thr(4093);
      measure(1'b0, 3'd0, 8'd0, per, hi);
      check(per == 4096 - ((n_list[i] > 4094) ? 4094 : n_list[i]),
            "R4 base clamp and period", per, 4096 - ((n_list[i] > 4094) ? 4094 : n_list[i]));
      check(hi == exp_high(n_list[i], 4093, 1'b0, 1'b1), "R6 high per base", hi,
            exp_high(n_list[i], 4093, 1'b0, 1'b1));
    end

    // R4: base write during a period applies at the next wrap
    set_base(4088);
    set_thr(4092);
    measure(1'b0, 3'd0, 8'd0, per, hi);
    measure(1'b1, 3'd0, 8'hF4, per, hi);
    check(per == 8, "R4 running period undisturbed", per, 8);
    measure(1'b0, 3'd0, 8'd0, per, hi);
    check(per == 12, "R4 new base after wrap", per, 12);
    check(hi == 8, "R6 high with new base", hi, 8);

    // R5: threshold low-byte write mid-period takes effect at next wrap
    set_base(4088);
    measure(1'b0, 3'd0, 8'd0, per, hi);
    measure(1'b1, 3'd3, 8'hFE, per, hi);
    check(hi == 4, "R5 current period keeps old threshold", hi, 4);
    measure(1'b0, 3'd0, 8'd0, per, hi);
    check(hi == 6, "R5 staged threshold active after wrap", hi, 6);

    // R7: lone high-byte write locks the compare
    wr(3'd2, 8'h0F);
    measure(1'b0, 3'd0, 8'd0, per, hi);
    check(hi == 8, "R7 locked compare holds high", hi, 8);
    measure(1'b0, 3'd0, 8'd0, per, hi);
    check(hi == 8, "R7 still locked next period", hi, 8);
    wr(3'd3, 8'hFA);
    measure(1'b0, 3'd0, 8'd0, per, hi);
    check(hi == 2, "R7 compare released by low byte", hi, 2);

    // R8: threshold equal to base with inversion gives 100%
    set_thr(4088);
    wr(3'd4, 8'h03);
    measure(1'b0, 3'd0, 8'd0, per, hi);
    check(hi == 8, "R8 full duty by inversion", hi, 8);

    // R9: disabled output stays low, counting continues
    wr(3'd4, 8'h02);
    measure(1'b0, 3'd0, 8'd0, per, hi);
    check(hi == 0, "R9 disabled output low", hi, 0);
    check(per == 8, "R9 counting continues", per, 8);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int n_list[4] = '{4094, 4095, 4090, 4080};
endmodule